// File: doc/BRIEF.md
# PLL Power-Up Sequencer with Requester Voting

This block drives the three control pins of an analog PLL: bypass (active low), reset (active low) and output gate. It has two modes. In manual mode, software writes a mode register and the pins follow its low bits. In vote mode, an internal state machine powers the PLL up and down by itself, driven by the OR of a per-requester vote register.

The power-up runs in a fixed order. First a bias-settle wait is made while the PLL is still in bypass and reset. Then bypass is released. After a minimum gap, reset is released. The state machine then waits for lock, and only after lock does it turn on the output gate. All waits are counted in ticks of a prescaler that divides the reference clock. If lock does not arrive in time, a sticky timeout flag is set, the PLL returns to bypass-and-reset, and the state machine does not retry until every vote has dropped and a new vote arrives. When the last vote clears, the output gate, bypass and reset all return to their off values on the same cycle.

A small register port gives access to three registers: the mode register (address 0), the vote register (address 1) and a read-only status register (address 2). Each requester has its own acknowledge output. This output is high while that requester votes and the PLL is fully running.

Top module: `pll_pwrseq`

## Requirements
- R1: After reset, all three pins are low. The mode register (address 0) reads 0x204800: hold bit 21 set, bias count 1 in bits 19:14, lock count 8 in bits 13:8. The vote register (address 1) reads 0 and the status register (address 2) reads 0.
- R2: With mode bit 20 clear, the pins follow the mode register one cycle after a write: bit 0 drives the output gate, bit 1 drives bypass-release, and bit 2 drives reset-release. Status bit 0 reads 1 exactly when all three pins are high.
- R3: In vote mode, the power-up order is fixed. Bypass is released first. Reset is released no less than GAP_TICKS ticks later. The output gate rises only after the synchronized lock input is seen.
- R4: Before bypass is released, the block waits (bias count + 1) ticks. A bias count of 0 gives a one-tick wait. The lock wait is (lock count + 1) ticks.
- R5: If lock is not seen within the lock wait, status bit 1 becomes 1 and the pins return to all low. The output gate never rises, and there is no retry while any vote stays set.
- R6: The timeout flag stays set after the votes drop. It clears when a new power-up starts, and that power-up can complete.
- R7: The PLL keeps running while any bit of the vote register is set. When the last vote clears, all three pins fall on the same cycle.
- R8: If every vote drops during the power-up, the sequence aborts. The pins return to all low, reset is not released afterwards, and no timeout is recorded.
- R9: Output voteAck[i] is 1 exactly when vote bit i is set and status bit 0 is 1.
- R10: In vote mode, setting mode bit 21 forces the pins low. Clearing it lets the sequencer power up again for the votes that are present.
- R11: Status bit 16 reports the lock input after a synchronizer. It follows the lock input in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 mode, 1 vote) |
| wrData | input | 32 | Write data |
| rdAddr | input | 2 | Read address (0 mode, 1 vote, 2 status) |
| rdData | output | 32 | Read data, combinational |
| pllLockDet | input | 1 | Asynchronous lock indication from the PLL |
| pllBypassN | output | 1 | Bypass control, 1 leaves bypass |
| pllResetN | output | 1 | PLL reset, active low |
| pllOutEn | output | 1 | PLL output gate |
| voteAck | output | NUM_VOTERS | Per-requester running acknowledge |

## Verification
A state machine stuck in the wrong step shows at the pins within two cycles, because the pins are registered one stage after the state. It shows up as reset released while still in bypass, an output gate that rises with no lock, or a partial power-down where the three pins do not fall together. Timer faults only show up over whole tick windows. For that reason the bench measures the settle delay, the bypass-to-reset gap and the lock timeout in cycles, and checks each against a window of about one cycle around the expected tick count. Errors in the sticky flag and in the retry rule stay hidden until a later vote sequence, so the bench runs the drop-and-revote pattern explicitly.

// File: rtl/pll_pwrseq_pkg.sv
`timescale 1ns/1ps
package pll_pwrseq_pkg;

  localparam int MODE_OUT_BIT  = 0;
  localparam int MODE_BYP_BIT  = 1;
  localparam int MODE_RST_BIT  = 2;
  localparam int MODE_LOCK_LSB = 8;
  localparam int MODE_BIAS_LSB = 14;
  localparam int MODE_CNT_W    = 6;
  localparam int MODE_VOTE_BIT = 20;
  localparam int MODE_HOLD_BIT = 21;

  localparam int STAT_ACT_BIT  = 0;
  localparam int STAT_TMO_BIT  = 1;
  localparam int STAT_LOCK_BIT = 16;

  localparam logic [31:0] MODE_RESET = 32'h0020_4800;
  localparam logic [31:0] MODE_WMASK = 32'h003F_FF0F;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_VOTE = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef enum logic [2:0] {
    ST_OFF, ST_SETTLE, ST_GAP, ST_LOCKW, ST_RUN, ST_FAIL
  } seqState_t;

  typedef enum logic [1:0] {TGT_BIAS, TGT_GAP, TGT_LOCK} tgtSel_t;

  typedef struct packed {
    logic    bypassN;
    logic    resetN;
    logic    outEn;
    logic    restart;
    tgtSel_t tgt;
    logic    setTimeout;
    logic    clrTimeout;
  } seqCmd_t;

endpackage

// File: rtl/pll_pwrseq_ctrl.sv
`timescale 1ns/1ps
module pll_pwrseq_ctrl
  import pll_pwrseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      fsmEn,
  input  logic      anyVote,
  input  logic      timerDone,
  input  logic      lockSync,
  output seqCmd_t   cmd,
  output seqState_t stateQ
);

  seqState_t stateNxt;

  always_comb begin
    stateNxt = stateQ;
    if (!fsmEn) begin
      stateNxt = ST_OFF;
    end else begin
      unique case (stateQ)
        ST_OFF:    if (anyVote) stateNxt = ST_SETTLE;
        ST_SETTLE: if (!anyVote) stateNxt = ST_OFF;
                   else if (timerDone) stateNxt = ST_GAP;
        ST_GAP:    if (!anyVote) stateNxt = ST_OFF;
                   else if (timerDone) stateNxt = ST_LOCKW;
        ST_LOCKW:  if (!anyVote) stateNxt = ST_OFF;
                   else if (lockSync) stateNxt = ST_RUN;
                   else if (timerDone) stateNxt = ST_FAIL;
        ST_RUN:    if (!anyVote) stateNxt = ST_OFF;
        ST_FAIL:   if (!anyVote) stateNxt = ST_OFF;
        default:   stateNxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    cmd            = '0;
    cmd.restart    = (stateNxt != stateQ);
    cmd.clrTimeout = (stateQ == ST_OFF) && (stateNxt == ST_SETTLE);
    cmd.setTimeout = (stateQ == ST_LOCKW) && (stateNxt == ST_FAIL);
    cmd.bypassN    = (stateQ == ST_GAP) || (stateQ == ST_LOCKW) || (stateQ == ST_RUN);
    cmd.resetN     = (stateQ == ST_LOCKW) || (stateQ == ST_RUN);
    cmd.outEn      = (stateQ == ST_RUN);
    unique case (stateQ)
      ST_GAP:   cmd.tgt = TGT_GAP;
      ST_LOCKW: cmd.tgt = TGT_LOCK;
      default:  cmd.tgt = TGT_BIAS;
    endcase
  end

endmodule

// File: rtl/pll_pwrseq_dp.sv
`timescale 1ns/1ps
module pll_pwrseq_dp
  import pll_pwrseq_pkg::*;
#(
  parameter int NUM_VOTERS  = 4,
  parameter int TICK_DIV    = 200,
  parameter int GAP_TICKS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [31:0]           wrData,
  input  logic [1:0]            rdAddr,
  output logic [31:0]           rdData,
  input  logic                  pllLockDet,
  input  seqCmd_t               cmd,
  output logic                  anyVote,
  output logic                  fsmEn,
  output logic                  voteMode,
  output logic                  timerDone,
  output logic                  lockSync,
  output logic                  timeoutFlag,
  output logic                  pllBypassN,
  output logic                  pllResetN,
  output logic                  pllOutEn,
  output logic [NUM_VOTERS-1:0] voteAck
);

  localparam int CNT_MAX   = 1 << MODE_CNT_W;
  localparam int MAX_TICKS = (GAP_TICKS > CNT_MAX) ? GAP_TICKS : CNT_MAX;
  localparam int TW        = $clog2(MAX_TICKS + 1);

  logic [31:0]           modeReg;
  logic [NUM_VOTERS-1:0] voteReg;
  logic [TW-1:0]         tickCnt;
  logic [TW-1:0]         target;
  logic                  tick;
  logic [2:0]            pinQ;
  logic                  active;
  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_RESET;
      voteReg <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_MODE) modeReg <= wrData & MODE_WMASK;
      if (wrAddr == ADDR_VOTE) voteReg <= wrData[NUM_VOTERS-1:0];
    end
  end

  assign anyVote  = |voteReg;
  assign voteMode = modeReg[MODE_VOTE_BIT];
  assign fsmEn    = voteMode && !modeReg[MODE_HOLD_BIT];

  // reference-tick prescaler, restarted at each sequencer step
  if (TICK_DIV == 1) begin : g_noPre
    assign tick = 1'b1;
  end else begin : g_pre
    localparam int PW = $clog2(TICK_DIV);
    logic [PW-1:0] preCnt;
    always_ff @(posedge clk) begin
      if (!rstN || cmd.restart)              preCnt <= '0;
      else if (preCnt == PW'(TICK_DIV - 1))  preCnt <= '0;
      else                                   preCnt <= preCnt + PW'(1);
    end
    assign tick = (preCnt == PW'(TICK_DIV - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.restart)        tickCnt <= '0;
    else if (tick && tickCnt != '1)  tickCnt <= tickCnt + TW'(1);
  end

  always_comb begin
    unique case (cmd.tgt)
      TGT_GAP:  target = TW'(GAP_TICKS);
      TGT_LOCK: target = TW'(modeReg[MODE_LOCK_LSB +: MODE_CNT_W]) + TW'(1);
      default:  target = TW'(modeReg[MODE_BIAS_LSB +: MODE_CNT_W]) + TW'(1);
    endcase
  end

  assign timerDone = (tickCnt >= target);

  always_ff @(posedge clk) begin
    if (!rstN)               timeoutFlag <= 1'b0;
    else if (cmd.clrTimeout) timeoutFlag <= 1'b0;
    else if (cmd.setTimeout) timeoutFlag <= 1'b1;
  end

  if (SYNC_STAGES == 1) begin : g_sync1
    always_ff @(posedge clk) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= pllLockDet;
    end
  end else begin : g_syncN
    always_ff @(posedge clk) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], pllLockDet};
    end
  end
  assign lockSync = syncQ[SYNC_STAGES-1];

  // pin register: index 0 gate, 1 bypass release, 2 reset release
  always_ff @(posedge clk) begin
    if (!rstN)         pinQ <= '0;
    else if (voteMode) pinQ <= {cmd.resetN, cmd.bypassN, cmd.outEn};
    else               pinQ <= {modeReg[MODE_RST_BIT], modeReg[MODE_BYP_BIT],
                                modeReg[MODE_OUT_BIT]};
  end

  assign pllOutEn   = pinQ[0];
  assign pllBypassN = pinQ[1];
  assign pllResetN  = pinQ[2];
  assign active     = &pinQ;

  for (genvar i = 0; i < NUM_VOTERS; i++) begin : g_ack
    assign voteAck[i] = voteReg[i] & active;
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_MODE: rdData = modeReg;
      ADDR_VOTE: rdData[NUM_VOTERS-1:0] = voteReg;
      ADDR_STAT: begin
        rdData[STAT_ACT_BIT]  = active;
        rdData[STAT_TMO_BIT]  = timeoutFlag;
        rdData[STAT_LOCK_BIT] = lockSync;
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/pll_pwrseq.sv
`timescale 1ns/1ps
module pll_pwrseq
  import pll_pwrseq_pkg::*;
#(
  parameter int NUM_VOTERS  = 4,
  parameter int TICK_DIV    = 200,
  parameter int GAP_TICKS   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [31:0]           wrData,
  input  logic [1:0]            rdAddr,
  output logic [31:0]           rdData,
  input  logic                  pllLockDet,
  output logic                  pllBypassN,
  output logic                  pllResetN,
  output logic                  pllOutEn,
  output logic [NUM_VOTERS-1:0] voteAck
);

  seqCmd_t   cmd;
  seqState_t stateQ;
  logic      anyVote, fsmEn, voteMode, timerDone, lockSync, timeoutFlag;

  pll_pwrseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fsmEn     (fsmEn),
    .anyVote   (anyVote),
    .timerDone (timerDone),
    .lockSync  (lockSync),
    .cmd       (cmd),
    .stateQ    (stateQ)
  );

  pll_pwrseq_dp #(
    .NUM_VOTERS  (NUM_VOTERS),
    .TICK_DIV    (TICK_DIV),
    .GAP_TICKS   (GAP_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .pllLockDet  (pllLockDet),
    .cmd         (cmd),
    .anyVote     (anyVote),
    .fsmEn       (fsmEn),
    .voteMode    (voteMode),
    .timerDone   (timerDone),
    .lockSync    (lockSync),
    .timeoutFlag (timeoutFlag),
    .pllBypassN  (pllBypassN),
    .pllResetN   (pllResetN),
    .pllOutEn    (pllOutEn),
    .voteAck     (voteAck)
  );

endmodule

// File: rtl/pll_pwrseq_chk.sv
`timescale 1ns/1ps
module pll_pwrseq_chk
  import pll_pwrseq_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      pllBypassN,
  input logic      pllResetN,
  input logic      pllOutEn,
  input logic      voteMode,
  input logic      fsmEn,
  input logic      anyVote,
  input logic      timeoutFlag,
  input seqState_t stateQ
);

  // R3: in vote mode reset is released only once bypass has been left
  a_r3_reset_after_bypass: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pllResetN) && $past(voteMode)) |-> $past(pllBypassN));

  // R3: output gate turns on only with bypass and reset already released
  a_r3_gate_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pllOutEn) && $past(voteMode)) |-> ($past(pllResetN) && $past(pllBypassN)));

  // R7: power-down in vote mode drops every pin on the same cycle
  a_r7_pins_drop_together: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pllBypassN) && $past(voteMode)) |-> (!pllResetN && !pllOutEn));

  // R5: a new timeout never coexists with an open output gate
  a_r5_timeout_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> !pllOutEn);

  // R8: losing the last vote returns the sequencer to its off step
  a_r8_abort_to_off: assert property (@(posedge clk) disable iff (!rstN)
    (fsmEn && $past(anyVote) && !anyVote) |=> (stateQ == ST_OFF));

  // R10: a held sequencer in vote mode keeps all pins low
  a_r10_hold_pins_off: assert property (@(posedge clk) disable iff (!rstN)
    (voteMode && !fsmEn && $past(voteMode && !fsmEn) && $past(voteMode && !fsmEn, 2))
      |-> (!pllBypassN && !pllResetN && !pllOutEn));

endmodule

bind pll_pwrseq pll_pwrseq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .pllBypassN  (pllBypassN),
  .pllResetN   (pllResetN),
  .pllOutEn    (pllOutEn),
  .voteMode    (voteMode),
  .fsmEn       (fsmEn),
  .anyVote     (anyVote),
  .timeoutFlag (timeoutFlag),
  .stateQ      (stateQ)
);

// File: tb/pll_pwrseq_tb.sv
`timescale 1ns/1ps
module pll_pwrseq_tb;

  localparam int NV       = 4;
  localparam int DIV      = 4;
  localparam int GAP      = 10;
  localparam int LOCK_DLY = 12;
  localparam logic [31:0] VOTE_EN = 32'h0010_0000;
  localparam logic [31:0] HOLD    = 32'h0020_0000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrAddr = '0;
  logic [31:0]   wrData = '0;
  logic [1:0]    rdAddr = '0;
  logic [31:0]   rdData;
  logic          pllLockDet = 1'b0;
  logic          pllBypassN, pllResetN, pllOutEn;
  logic [NV-1:0] voteAck;

  int  checks = 0;
  int  failures = 0;
  bit  lockAllow = 1'b1;
  int  lockCnt = 0;

  always #2.5 clk = ~clk;

  pll_pwrseq #(.NUM_VOTERS(NV), .TICK_DIV(DIV), .GAP_TICKS(GAP), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pllLockDet(pllLockDet),
    .pllBypassN(pllBypassN), .pllResetN(pllResetN), .pllOutEn(pllOutEn),
    .voteAck(voteAck)
  );

  // lock model: lock comes LOCK_DLY cycles after reset release
  always @(negedge clk) begin
    if (pllResetN && lockAllow) lockCnt <= lockCnt + 1;
    else                        lockCnt <= 0;
    pllLockDet <= pllResetN && lockAllow && (lockCnt >= LOCK_DLY);
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input string what, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  function automatic logic [2:0] pins();
    return {pllResetN, pllBypassN, pllOutEn};
  endfunction

  // waits until pin selected by sel (0 gate,1 bypass,2 reset) equals val
  task automatic waitPin(input int sel, input logic val, input int maxCyc, output int n);
    n = 0;
    while (pins()[sel] !== val && n < maxCyc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic powerOff();
    int n;
    wr(2'd1, 32'h0);
    waitPin(1, 1'b0, 10, n);
    repeat (4) @(negedge clk);
  endtask

  task automatic tReset();
    logic [31:0] d;
    chk("R1", "pins after reset", pins(), 3'b000);
    rd(2'd0, d); chk("R1", "mode reset value", d, 32'h0020_4800);
    rd(2'd1, d); chk("R1", "vote reset value", d, 0);
    rd(2'd2, d); chk("R1", "status reset value", d, 0);
  endtask

  task automatic tManual();
    logic [31:0] d;
    wr(2'd0, 32'h2);
    @(negedge clk);
    chk("R2", "manual bypass-only pins", pins(), 3'b010);
    rd(2'd2, d); chk("R2", "status active with partial pins", d[0], 0);
    wr(2'd0, 32'h7);
    @(negedge clk);
    chk("R2", "manual all pins", pins(), 3'b111);
    rd(2'd2, d); chk("R2", "status active bit", d[0], 1);
    chk("R9", "ack without votes", voteAck, 0);
    repeat (20) @(negedge clk);
    rd(2'd2, d); chk("R11", "lock bit in manual mode", d[16], 1);
    wr(2'd0, 32'h0);
    @(negedge clk);
    chk("R2", "manual pins cleared", pins(), 3'b000);
    repeat (6) @(negedge clk);
    rd(2'd2, d); chk("R11", "lock bit cleared", d[16], 0);
  endtask

  task automatic tPowerUp(input int bias);
    int nB, nR, nO;
    logic [31:0] d;
    wr(2'd0, VOTE_EN | (32'(bias) << 14) | (32'd8 << 8));
    wr(2'd1, 32'h1);
    waitPin(1, 1'b1, 500, nB);
    chkRange("R4", "settle cycles to bypass release", nB, bias*DIV + DIV + 2, bias*DIV + DIV + 4);
    chk("R3", "reset held at bypass release", pllResetN, 0);
    waitPin(2, 1'b1, 500, nR);
    chkRange("R3", "bypass-to-reset gap", nR, GAP*DIV, GAP*DIV + 2);
    chk("R3", "gate off at reset release", pllOutEn, 0);
    waitPin(0, 1'b1, 200, nO);
    chkRange("R3", "gate after lock", nO, LOCK_DLY, LOCK_DLY + 8);
    rd(2'd2, d); chk("R11", "status lock and active", d & 32'h1_0003, 32'h1_0001);
    chk("R9", "ack single voter", voteAck, 4'b0001);
  endtask

  task automatic tVoteOr();
    int n;
    logic [2:0] prev;
    bit ok;
    wr(2'd1, 32'h6);
    repeat (5) @(negedge clk);
    chk("R7", "running with other votes", pins(), 3'b111);
    chk("R9", "ack follows votes", voteAck, 4'b0110);
    wr(2'd1, 32'h4);
    repeat (5) @(negedge clk);
    chk("R7", "running with one vote left", pins(), 3'b111);
    prev = pins();
    wr(2'd1, 32'h0);
    ok = 1'b0;
    for (int i = 0; i < 6 && !ok; i++) begin
      if (pins() != prev) begin
        chk("R7", "first change on power-down", pins(), 3'b000);
        ok = 1'b1;
      end
      @(negedge clk);
    end
    chk("R7", "power-down seen", ok, 1);
    chk("R9", "ack cleared", voteAck, 0);
  endtask

  task automatic tAbort();
    int n;
    bit rel;
    logic [31:0] d;
    wr(2'd1, 32'h8);
    waitPin(1, 1'b1, 500, n);
    wr(2'd1, 32'h0);
    waitPin(1, 1'b0, 4, n);
    chk("R8", "abort from gap step", pins(), 3'b000);
    rel = 1'b0;
    repeat (60) begin @(negedge clk); if (pllResetN) rel = 1'b1; end
    chk("R8", "reset not released after abort", rel, 0);
    lockAllow = 1'b0;
    wr(2'd1, 32'h2);
    waitPin(2, 1'b1, 500, n);
    wr(2'd1, 32'h0);
    waitPin(1, 1'b0, 4, n);
    chk("R8", "abort from lock wait", pins(), 3'b000);
    rd(2'd2, d); chk("R8", "no timeout after abort", d[1], 0);
    lockAllow = 1'b1;
  endtask

  task automatic tTimeout();
    int n;
    bit gate;
    logic [31:0] d;
    lockAllow = 1'b0;
    wr(2'd1, 32'h1);
    waitPin(2, 1'b1, 500, n);
    gate = 1'b0; n = 0;
    while (pllResetN && n < 100) begin
      @(negedge clk); n++;
      if (pllOutEn) gate = 1'b1;
    end
    chkRange("R5", "lock wait length", n, 9*DIV, 9*DIV + 2);
    chk("R5", "gate never opened", gate, 0);
    chk("R5", "pins off after timeout", pins(), 3'b000);
    rd(2'd2, d); chk("R5", "timeout flag", d[1], 1);
    lockAllow = 1'b1;
    repeat (100) @(negedge clk);
    chk("R5", "no retry while vote held", pins(), 3'b000);
    wr(2'd1, 32'h0);
    repeat (5) @(negedge clk);
    rd(2'd2, d); chk("R6", "timeout sticky after votes drop", d[1], 1);
    wr(2'd1, 32'h1);
    waitPin(0, 1'b1, 300, n);
    chk("R6", "retry completes", pins(), 3'b111);
    rd(2'd2, d); chk("R6", "timeout cleared on retry", d[1], 0);
  endtask

  task automatic tHold();
    int n;
    wr(2'd0, VOTE_EN | HOLD | (32'd1 << 14) | (32'd8 << 8));
    repeat (3) @(negedge clk);
    chk("R10", "hold forces pins low", pins(), 3'b000);
    repeat (30) @(negedge clk);
    chk("R10", "pins stay low while held", pins(), 3'b000);
    wr(2'd0, VOTE_EN | (32'd1 << 14) | (32'd8 << 8));
    waitPin(0, 1'b1, 300, n);
    chk("R10", "power-up after hold released", pins(), 3'b111);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tManual();
    tPowerUp(1);
    powerOff();
    tPowerUp(0);
    powerOff();
    tPowerUp(5);
    tVoteOr();
    tAbort();
    tTimeout();
    tHold();
    powerOff();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule